// File: doc/BRIEF.md
# Cascaded Pipelined Eight-Tap FIR Filter

This block is a fully parallel finite impulse response filter with eight taps on 18-bit signed two's complement samples. Every accepted sample produces one filtered output. The block computes all eight products in parallel. They are summed in two groups of four. Each group is a multiply-add stage: it registers both operands of every multiplier, registers every product and registers the adder result.

The first group, taps 1 to 4, sends its full-precision sum forward on a registered 44-bit chain. The second group, taps 5 to 8, adds its own sum to that chain value in a registered chain adder. One extra compensation register on the second group's sum makes the two partial sums that meet belong to the same output sample. Rounding and saturation happen only once, on the complete 44-bit total, and give an 18-bit signed result.

The coefficients are fixed by a parameter. The block is meant for a streaming datapath where samples arrive with a valid strobe that may have gaps.

Top module: `fir8_cascade`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears the sample history and all pipeline registers. After that edge, `out_valid` is 0 and `out_data` is 0. Samples accepted after reset see zeros as their history.
- R2: `out_valid` goes high for exactly one cycle, 6 rising edges after each edge at which `in_valid` was high. At no other time is it high.
- R3: For an accepted sample, the output is round(Σ c[k]·x[n−k] / 2^RSHIFT) for k = 0..7, with RSHIFT = 15 by default. Here x[n] is the newest sample and x[n−k] is the sample accepted k valid strobes earlier. With default parameters the coefficients c[0..7] are 3000, −1500, 7000, 16000, 12000, 4500, −2500, 900. Element k of `COEFS` is c[k].
- R4: Cycles with `in_valid` low leave the sample history unchanged. History advances by one position only on a cycle where `in_valid` is high.
- R5: A rounded total above 131071 is output as 131071. A rounded total below −131072 is output as −131072.
- R6: Rounding is half-up. A total whose discarded fraction is exactly one half rounds toward positive infinity, for both positive and negative totals.
- R7: The first group's sum and the chain carry full precision with no intermediate rounding or truncation. The contributions of taps 5 to 8 line up with those of taps 1 to 4 for the same output sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; the sample is accepted when high |
| in_data | input | 18 | Signed input sample |
| out_valid | output | 1 | Marks a filtered result |
| out_data | output | 18 | Signed filtered result, rounded and saturated |

## Verification
An impulse of 32768 reads every coefficient back in order, one per output. A stage misaligned by one cycle would show taps 5 to 8 one output early or late. A swapped coefficient order would show a reversed response.

Runs of input with idle gaps catch a history that shifts when no sample is accepted. Such a design would repeat or drop samples in the convolution.

Full-scale positive and negative steps drive the total past both limits. A design that wraps instead of clamping would flip the sign of the output.

Samples chosen so that the discarded fraction is exactly one half, with both signs, catch round-to-nearest-even and round-toward-zero. A reset in the middle of a stream checks that no stale history leaks into the next impulse response.

// File: rtl/fir8_pkg.sv
package fir8_pkg;
  // Rising edges from the accepting edge to the edge that updates out_data:
  // operand regs, product regs, group adder, chain link, chain adder, round/sat.
  localparam int FIR_PIPE_LAT = 6;
  // Number of four-product groups joined on the chain.
  localparam int FIR_NGRP     = 2;
endpackage

// File: rtl/fir8_tapline.sv
module fir8_tapline #(
  parameter int DW   = 18,
  parameter int NTAP = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_data,
  output logic [NTAP-1:0][DW-1:0]   taps
);
  // Position 0 holds the newest accepted sample.
  always_ff @(posedge clk) begin
    if (rst)           taps[0] <= '0;
    else if (in_valid) taps[0] <= in_data;
  end

  for (genvar k = 1; k < NTAP; k++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst)           taps[k] <= '0;
      else if (in_valid) taps[k] <= taps[k-1];
    end
  end

  // R4: a new sample enters only under the strobe
  assert_shift_in_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (taps[0] == $past(in_data)));
  // R4: idle cycles keep the whole history
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(taps));
endmodule

// File: rtl/fir8_mac4.sv
module fir8_mac4 #(
  parameter int DW      = 18,
  parameter int CW      = 18,
  parameter int GRP     = 4,
  parameter int CHW     = 44,
  parameter bit LINK_IN = 1'b0,
  parameter logic [GRP-1:0][CW-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [GRP-1:0][DW-1:0]   taps,
  input  logic [CHW-1:0]           link_in,
  output logic [CHW-1:0]           link_out
);
  localparam int PW = DW + CW;
  localparam int SW = PW + $clog2(GRP);

  logic signed [DW-1:0] xa [GRP];
  logic signed [CW-1:0] ca [GRP];
  logic signed [PW-1:0] pr [GRP];
  logic signed [SW-1:0] acc, acc_r;
  logic signed [CHW-1:0] acc_x;

  for (genvar k = 0; k < GRP; k++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst) begin
        xa[k] <= '0;
        ca[k] <= '0;
        pr[k] <= '0;
      end else begin
        xa[k] <= taps[k];
        ca[k] <= COEFS[k];
        pr[k] <= xa[k] * ca[k];
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < GRP; k++) acc = acc + SW'(pr[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_r <= '0;
    else     acc_r <= acc;
  end

  assign acc_x = CHW'(acc_r);

  if (LINK_IN) begin : g_link
    // Compensation register: matches the head group's registered chain output.
    logic signed [CHW-1:0] comp_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        comp_r   <= '0;
        link_out <= '0;
      end else begin
        comp_r   <= acc_x;
        link_out <= comp_r + link_in;
      end
    end
  end else begin : g_head
    logic unused_link;
    assign unused_link = ^link_in;
    always_ff @(posedge clk) begin
      if (rst) link_out <= '0;
      else     link_out <= acc_x;
    end
  end
endmodule

// File: rtl/fir8_round_sat.sv
module fir8_round_sat #(
  parameter int CHW    = 44,
  parameter int OW     = 18,
  parameter int RSHIFT = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CHW-1:0]  tot,
  output logic [OW-1:0]   y
);
  localparam logic signed [CHW-1:0] HALF = CHW'(1) << (RSHIFT - 1);
  localparam logic signed [CHW-1:0] MAXV = CHW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [CHW-1:0] MINV = -MAXV - CHW'(1);

  logic signed [CHW-1:0] biased, shifted;
  logic        [OW-1:0]  clamped;

  always_comb begin
    biased  = $signed(tot) + HALF;
    shifted = biased >>> RSHIFT;
    if (shifted > MAXV)      clamped = MAXV[OW-1:0];
    else if (shifted < MINV) clamped = MINV[OW-1:0];
    else                     clamped = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else     y <= clamped;
  end

  // R5: totals beyond the limits land on the limits
  assert_clamp_hi_R5: assert property (@(posedge clk) disable iff (rst)
    ((($signed(tot) + HALF) >>> RSHIFT) > MAXV) |=> (y == MAXV[OW-1:0]));
  assert_clamp_lo_R5: assert property (@(posedge clk) disable iff (rst)
    ((($signed(tot) + HALF) >>> RSHIFT) < MINV) |=> (y == MINV[OW-1:0]));
endmodule

// File: rtl/fir8_cascade.sv
module fir8_cascade
  import fir8_pkg::*;
#(
  parameter int DW     = 18,
  parameter int CW     = 18,
  parameter int GRP    = 4,
  parameter int CHW    = 44,
  parameter int OW     = 18,
  parameter int RSHIFT = 15,
  parameter logic [FIR_NGRP*GRP-1:0][CW-1:0] COEFS = {
    18'sd900, -18'sd2500, 18'sd4500, 18'sd12000,
    18'sd16000, 18'sd7000, -18'sd1500, 18'sd3000 }
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int NTAP = FIR_NGRP * GRP;
  localparam int LAT  = FIR_PIPE_LAT;
  localparam int AGEW = $clog2(LAT + 2) + 1;

  logic [NTAP-1:0][DW-1:0] taps;
  logic [CHW-1:0]          link_w [FIR_NGRP+1];
  logic [LAT:0]            vld_sr;

  fir8_tapline #(.DW(DW), .NTAP(NTAP)) u_tapline (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .taps(taps));

  assign link_w[0] = '0;

  for (genvar g = 0; g < FIR_NGRP; g++) begin : g_grp
    fir8_mac4 #(
      .DW(DW), .CW(CW), .GRP(GRP), .CHW(CHW),
      .LINK_IN(g > 0),
      .COEFS(COEFS[g*GRP +: GRP])
    ) u_mac4 (
      .clk(clk), .rst(rst),
      .taps(taps[g*GRP +: GRP]),
      .link_in(link_w[g]),
      .link_out(link_w[g+1]));
  end

  fir8_round_sat #(.CHW(CHW), .OW(OW), .RSHIFT(RSHIFT)) u_round_sat (
    .clk(clk), .rst(rst), .tot(link_w[FIR_NGRP]), .y(out_data));

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LAT-1:0], in_valid};
  end
  assign out_valid = vld_sr[LAT];

  // Edges since reset release, for the latency check below.
  logic [AGEW-1:0] chk_age;
  always_ff @(posedge clk) begin
    if (rst)                       chk_age <= '0;
    else if (chk_age <= AGEW'(LAT)) chk_age <= chk_age + 1'b1;
  end

  // R1: reset clears the output side
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
  // R2: one result per accepted sample, fixed latency
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (chk_age >= AGEW'(LAT + 1)) |-> (out_valid == $past(in_valid, LAT + 1)));
endmodule

// File: tb/fir8_cascade_bench.sv
`timescale 1ns/1ps
module fir8_cascade_bench;
  localparam int RS  = 15;
  localparam int LAT = 6;
  localparam longint OMAX = 131071;
  localparam longint OMIN = -131072;
  int coef [8] = '{3000, -1500, 7000, 16000, 12000, 4500, -2500, 900};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [17:0] in_data = '0;
  logic out_valid;
  logic [17:0] out_data;

  always #4 clk = ~clk;

  fir8_cascade u_fir8_cascade (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  longint hist [8];
  longint exp_q [$];
  int     due_q [$];

  function automatic longint model();
    longint acc = 0, r;
    for (int k = 0; k < 8; k++) acc += longint'(coef[k]) * hist[k];
    r = (acc + (64'sd1 <<< (RS - 1))) >>> RS;
    if (r > OMAX) r = OMAX;
    if (r < OMIN) r = OMIN;
    return r;
  endfunction

  task automatic check(input string tag, input bit in_rst);
    bit ev;
    longint got;
    n_vec++;
    got = longint'($signed(out_data));
    if (in_rst) begin
      if (out_valid !== 1'b0 || out_data !== 18'd0) begin
        n_bad++;
        $display("FAIL R1 reset: valid=%0b data=%0d, expected valid=0 data=0", out_valid, got);
      end
      return;
    end
    ev = (due_q.size() > 0) && (due_q[0] == cyc);
    if (out_valid !== ev) begin
      n_bad++;
      $display("FAIL R2 (%s) cycle %0d: out_valid=%0b expected %0b", tag, cyc, out_valid, ev);
    end
    if (ev) begin
      if (got != exp_q[0]) begin
        n_bad++;
        $display("FAIL %s cycle %0d: out_data=%0d expected %0d", tag, cyc, got, exp_q[0]);
      end
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
    end
  endtask

  task automatic tick(input bit v, input int d, input string tag);
    bit r;
    in_valid = v;
    in_data  = d[17:0];
    r = rst;
    @(posedge clk);
    cyc++;
    if (v && !r) begin
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(d);
      exp_q.push_back(model());
      due_q.push_back(cyc + LAT);
    end
    @(negedge clk);
    check(tag, r);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int k = 0; k < 8; k++) hist[k] = 0;
    exp_q.delete();
    due_q.delete();
    repeat (3) tick(1'b1, 77, "R1");
    rst = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (LAT + 2) tick(1'b0, 0, tag);
  endtask

  function automatic int tie_sample();
    for (int x = 1; x < 131072; x++)
      if (((coef[0] * x) % 32768) == 16384) return x;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int tx;
    @(negedge clk);
    do_reset();                                   // R1 reset state
    // R3 / R7: impulse of 2^15 reads each coefficient back in order
    tick(1'b1, 32768, "R3");
    for (int i = 0; i < 9; i++) tick(1'b1, 0, "R7");
    drain("R2");
    // R4: impulse with idle gaps between strobes
    tick(1'b1, 32768, "R4");
    for (int i = 0; i < 9; i++) begin
      tick(1'b0, 12345, "R4");
      tick(1'b0, -999, "R4");
      tick(1'b1, 0, "R4");
    end
    drain("R4");
    // R5: full-scale steps both ways
    for (int i = 0; i < 12; i++) tick(1'b1, 131071, "R5");
    for (int i = 0; i < 12; i++) tick(1'b1, -131072, "R5");
    drain("R5");
    // R1: reset mid-stream, then impulse must show no stale history
    tick(1'b1, 50000, "R3");
    tick(1'b1, -60000, "R3");
    do_reset();
    tick(1'b1, 32768, "R1");
    for (int i = 0; i < 8; i++) tick(1'b1, 0, "R1");
    drain("R1");
    // R6: exact half ties, positive and negative
    tx = tie_sample();
    do_reset();
    tick(1'b1, tx, "R6");
    tick(1'b1, 0, "R6");
    tick(1'b1, -tx, "R6");
    for (int i = 0; i < 8; i++) tick(1'b1, 0, "R6");
    drain("R6");
    // R3: random stream with random gaps
    for (int i = 0; i < 400; i++) begin
      int d;
      d = int'($urandom_range(0, 262143)) - 131072;
      tick(($urandom_range(0, 9) < 7), d, "R3");
    end
    drain("R3");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule